// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Engine

This block produces the clocked word stream of a synchronous burst read. A 16-bit configuration word is loaded through a small write port and sets the engine's behaviour: the initial latency, whether the engine is enabled at all, how long each word stays on the output, how many words a burst carries, how addresses step at a block boundary, which clock edge is active, and the polarity and timing of a wait indication. The words come from an internal read-only array whose contents are computed from the address.

A host starts a burst by holding the chip enable low and pulsing the address-valid strobe low. The engine captures the start address at the first active clock edge that sees both low. After the programmed latency it presents one word per step until a fixed-length burst completes, or until the chip enable rises. The output enable only gates what is visible on the outputs. The address sequence keeps advancing while the outputs are gated.

Top module: `burst_read_engine`

## Requirements
- R1: After reset the configuration holds 16'hA4C7. This value has bit 15 set (engine disabled), bits 13:11 = 4, bit 10 set, bits 7 and 6 set and bits 2:0 = 7. With the configuration at its reset value, dvalid_o and dout_o are 0 and wait_o is 0.
- R2: While configuration bit 15 is 1, no burst starts. dvalid_o stays 0 and wait_o stays at its inactive level.
- R3: A burst starts at an active edge that samples ce_n=0 and avd_n=0. That edge captures start_addr. With bits 13:11 = L (2 to 6), the first word becomes valid right after the L-th active edge that follows the start edge.
- R4: With bit 9 = 0 each word is valid for one active-edge interval. With bit 9 = 1 each word is valid for two intervals. The latency of R3 does not depend on bit 9.
- R5: Bits 2:0 set the burst length: 1 gives 4 words, 2 gives 8 words, 3 gives 16 words, and 7 gives a continuous burst. At the end of a fixed burst, dvalid_o returns to 0.
- R6: In a fixed burst with bit 3 = 0, addresses wrap inside the block of burst-length words aligned to that length. With bit 3 = 1, and in any continuous burst, addresses increment by one modulo the array depth.
- R7: With bit 8 = 0, the internal wait flag is set from the start edge until the edge that presents the first word. With bit 8 = 1, the flag clears one active edge earlier. The flag is clear at all other times.
- R8: With bit 10 = 1, wait_o is active high. With bit 10 = 0, wait_o is the inverse of the wait flag.
- R9: With bit 6 = 1, the engine works on the rising clock edge. With bit 6 = 0, it works on the falling edge.
- R10: A write with bits 13:11 outside 2..6 stores a latency of 4. A write with bits 2:0 not in {1,2,3,7} stores 7 (continuous). Bit 7 is always stored as 1, so ordering is always linear.
- R11: An active edge with ce_n=1 ends any burst, and both outputs become idle after that edge. A new avd_n pulse during a burst restarts the burst at the new address.
- R12: While oe_n=1, dvalid_o and dout_o are 0, but the sequence continues to advance.
- R13: The word at address a is the low 16 bits of (a*40503) XOR 16'h5A5A. dout_o is 0 when dvalid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| avd_n | input | 1 | Address-valid strobe, active low |
| start_addr | input | AW | Burst start address |
| cfg_we | input | 1 | Configuration write strobe (rising clk) |
| cfg_wdata | input | 16 | Configuration write data |
| dout_o | output | DW | Data word |
| dvalid_o | output | 1 | Data valid |
| wait_o | output | 1 | Wait indication, programmable polarity |

## Verification
The bench builds the block with its default parameters: a 64-word array with 16-bit words. With that depth, 16-word wrap blocks fit several times over. Start addresses near the top of the array make linear and continuous bursts cross from address 63 to 0. The bench sweeps every legal latency, every burst length, both boundary modes and both hold lengths, and it varies the clock edge, wait polarity and wait timing along the way. Other runs cover aborts, restarts, output gating and illegal field codes.

// File: rtl/bre_pkg.sv
package bre_pkg;

   localparam int CFG_W = 16;
   localparam logic [CFG_W-1:0] CFG_RESET = 16'hA4C7;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LAT,
      ST_DATA
   } seq_state_t;

   typedef struct packed {
      logic       sync_en;
      logic [2:0] lat;
      logic       wait_hi;
      logic       hold2;
      logic       wait_early;
      logic       rise;
      logic       wrap;
      logic       fixed;
      logic [2:0] len_lg;
   } cfg_t;

   // Replace illegal field codes with reset defaults before storage
   function automatic logic [CFG_W-1:0] cfg_sanitize(input logic [CFG_W-1:0] w);
      logic [CFG_W-1:0] r;
      r = w;
      if (w[13:11] < 3'd2 || w[13:11] > 3'd6) r[13:11] = CFG_RESET[13:11];
      if (!(w[2:0] inside {3'd1, 3'd2, 3'd3, 3'd7})) r[2:0] = CFG_RESET[2:0];
      r[7] = 1'b1;
      return r;
   endfunction

   function automatic cfg_t cfg_decode(input logic [CFG_W-1:0] r);
      cfg_t c;
      c.sync_en    = ~r[15];
      c.lat        = r[13:11];
      c.wait_hi    = r[10];
      c.hold2      = r[9];
      c.wait_early = r[8];
      c.rise       = r[6];
      c.wrap       = ~r[3];
      c.fixed      = (r[2:0] != 3'd7);
      c.len_lg     = (r[2:0] == 3'd1) ? 3'd2 : (r[2:0] == 3'd2) ? 3'd3 : 3'd4;
      return c;
   endfunction

endpackage

// File: rtl/bre_cfg_reg.sv
module bre_cfg_reg
   import bre_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output cfg_t             cfg
);

   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q <= CFG_RESET;
      else if (we) cfg_q <= cfg_sanitize(wdata);
   end

   assign cfg = cfg_decode(cfg_q);

endmodule

// File: rtl/bre_word_rom.sv
module bre_word_rom #(
   parameter int AW   = 6,
   parameter int DW   = 16,
   parameter int MULT = 40503,
   parameter int SEED = 'h5A5A
) (
   input  logic [AW-1:0] addr,
   output logic [DW-1:0] word
);

   localparam int DEPTH = 1 << AW;

   if (DEPTH > 4096) begin : g_depth_chk
      $error("bre_word_rom: array depth too large");
   end

   logic [DW-1:0] tbl [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
      assign tbl[i] = DW'((32'(i) * 32'(MULT)) ^ 32'(SEED));
   end

   assign word = tbl[addr];

endmodule

// File: rtl/bre_addr_step.sv
module bre_addr_step #(
   parameter int AW = 6
) (
   input  logic [AW-1:0] cur,
   input  logic          wrap_fixed,
   input  logic [2:0]    len_lg,
   output logic [AW-1:0] nxt
);

   logic [AW-1:0] inc;
   logic [AW-1:0] msk;

   always_comb begin
      inc = cur + 1'b1;
      msk = AW'((32'd1 << len_lg) - 32'd1);
      nxt = wrap_fixed ? ((cur & ~msk) | (inc & msk)) : inc;
   end

endmodule

// File: rtl/bre_seq.sv
module bre_seq
   import bre_pkg::*;
#(
   parameter int AW   = 6,
   parameter int LATW = 3,
   parameter int LENW = 5
) (
   input  logic            eclk,
   input  logic            rst_n,
   input  logic            ce_n,
   input  logic            avd_n,
   input  logic [AW-1:0]   start_addr,
   input  logic            sync_en,
   input  logic [LATW-1:0] lat,
   input  logic            hold2,
   input  logic            wait_early,
   input  logic            fixed,
   input  logic [2:0]      len_lg,
   input  logic [AW-1:0]   nxt_addr,
   output logic [AW-1:0]   addr_q,
   output logic            valid_q,
   output logic            wait_q
);

   seq_state_t      state;
   logic [LATW-1:0] cnt;
   logic            hold_q;
   logic [LENW-1:0] left;
   logic [LENW-1:0] len_words;

   assign len_words = LENW'(32'd1 << len_lg);

   always_ff @(posedge eclk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         addr_q  <= '0;
         hold_q  <= 1'b0;
         left    <= '0;
         valid_q <= 1'b0;
         wait_q  <= 1'b0;
      end else if (!sync_en || ce_n) begin
         state   <= ST_IDLE;
         valid_q <= 1'b0;
         wait_q  <= 1'b0;
      end else if (!avd_n) begin
         state   <= ST_LAT;
         addr_q  <= start_addr;
         cnt     <= lat;
         valid_q <= 1'b0;
         wait_q  <= 1'b1;
      end else begin
         unique case (state)
            ST_LAT: begin
               if (cnt <= LATW'(1)) begin
                  state   <= ST_DATA;
                  valid_q <= 1'b1;
                  wait_q  <= 1'b0;
                  hold_q  <= hold2;
                  left    <= len_words;
               end else begin
                  cnt    <= cnt - LATW'(1);
                  wait_q <= wait_early ? (cnt > LATW'(2)) : 1'b1;
               end
            end
            ST_DATA: begin
               if (hold_q) begin
                  hold_q <= 1'b0;
               end else if (fixed && left == LENW'(1)) begin
                  state   <= ST_IDLE;
                  valid_q <= 1'b0;
               end else begin
                  addr_q <= nxt_addr;
                  hold_q <= hold2;
                  if (fixed) left <= left - LENW'(1);
               end
            end
            default: begin
               valid_q <= 1'b0;
               wait_q  <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/burst_read_engine.sv
module burst_read_engine
   import bre_pkg::*;
#(
   parameter int AW   = 6,
   parameter int DW   = 16,
   parameter int MULT = 40503,
   parameter int SEED = 'h5A5A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          avd_n,
   input  logic [AW-1:0] start_addr,
   input  logic          cfg_we,
   input  logic [15:0]   cfg_wdata,
   output logic [DW-1:0] dout_o,
   output logic          dvalid_o,
   output logic          wait_o
);

   localparam int LATW = 3;
   localparam int LENW = 5;

   if (AW < 4) begin : g_aw_chk
      $error("burst_read_engine: AW must hold a 16-word block");
   end
   if (DW < 1 || DW > 32) begin : g_dw_chk
      $error("burst_read_engine: DW out of range");
   end

   cfg_t          cfg;
   logic          eclk;
   logic          c_sync;
   logic          c_wrapfix;
   logic [2:0]    c_lenlg;
   logic [AW-1:0] seq_addr;
   logic [AW-1:0] step_addr;
   logic          seq_valid;
   logic          seq_wait;
   logic [DW-1:0] rom_word;

   bre_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .cfg   (cfg)
   );

   assign eclk      = cfg.rise ? clk : ~clk;
   assign c_sync    = cfg.sync_en;
   assign c_wrapfix = cfg.wrap & cfg.fixed;
   assign c_lenlg   = cfg.len_lg;

   bre_addr_step #(.AW(AW)) u_step (
      .cur        (seq_addr),
      .wrap_fixed (c_wrapfix),
      .len_lg     (c_lenlg),
      .nxt        (step_addr)
   );

   bre_seq #(.AW(AW), .LATW(LATW), .LENW(LENW)) u_seq (
      .eclk       (eclk),
      .rst_n      (rst_n),
      .ce_n       (ce_n),
      .avd_n      (avd_n),
      .start_addr (start_addr),
      .sync_en    (c_sync),
      .lat        (cfg.lat),
      .hold2      (cfg.hold2),
      .wait_early (cfg.wait_early),
      .fixed      (cfg.fixed),
      .len_lg     (c_lenlg),
      .nxt_addr   (step_addr),
      .addr_q     (seq_addr),
      .valid_q    (seq_valid),
      .wait_q     (seq_wait)
   );

   bre_word_rom #(.AW(AW), .DW(DW), .MULT(MULT), .SEED(SEED)) u_rom (
      .addr (seq_addr),
      .word (rom_word)
   );

   assign dvalid_o = seq_valid & ~oe_n;
   assign dout_o   = dvalid_o ? rom_word : '0;
   assign wait_o   = cfg.wait_hi ? seq_wait : ~seq_wait;

endmodule

// File: rtl/bre_chk.sv
module bre_chk #(
   parameter int AW = 6
) (
   input logic          eclk,
   input logic          rst_n,
   input logic          ce_n,
   input logic          avd_n,
   input logic          sync_en,
   input logic          wrap_fixed,
   input logic [2:0]    len_lg,
   input logic [AW-1:0] addr_q,
   input logic          valid_q,
   input logic          wait_q
);

   logic [AW-1:0] msk;
   always_comb msk = AW'((32'd1 << len_lg) - 32'd1);

   // R11
   ce_stop_chk: assert property (@(posedge eclk) disable iff (!rst_n)
      ce_n |=> (!valid_q && !wait_q));

   // R2
   async_idle_chk: assert property (@(posedge eclk) disable iff (!rst_n)
      !sync_en |=> (!valid_q && !wait_q));

   // R7
   start_wait_chk: assert property (@(posedge eclk) disable iff (!rst_n)
      (sync_en && !ce_n && !avd_n) |=> (wait_q && !valid_q));

   // R7
   wait_data_excl_chk: assert property (@(posedge eclk) disable iff (!rst_n)
      valid_q |-> !wait_q);

   // R6
   wrap_block_chk: assert property (@(posedge eclk) disable iff (!rst_n)
      (valid_q && $past(valid_q) && wrap_fixed && (addr_q != $past(addr_q)))
      |-> ((addr_q & ~msk) == ($past(addr_q) & ~msk)));

endmodule

bind burst_read_engine bre_chk #(.AW(AW)) u_bre_chk (
   .eclk       (eclk),
   .rst_n      (rst_n),
   .ce_n       (ce_n),
   .avd_n      (avd_n),
   .sync_en    (c_sync),
   .wrap_fixed (c_wrapfix),
   .len_lg     (c_lenlg),
   .addr_q     (seq_addr),
   .valid_q    (seq_valid),
   .wait_q     (seq_wait)
);

// File: tb/burst_read_engine_bench.sv
module burst_read_engine_bench;

   localparam int CLK_PERIOD = 20;
   localparam int AW = 6;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1;
   logic          oe_n = 1'b1;
   logic          avd_n = 1'b1;
   logic [AW-1:0] start_addr = '0;
   logic          cfg_we = 1'b0;
   logic [15:0]   cfg_wdata = '0;
   logic [DW-1:0] dout_o;
   logic          dvalid_o;
   logic          wait_o;

   burst_read_engine u_burst_read_engine (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .avd_n(avd_n),
      .start_addr(start_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .dout_o(dout_o), .dvalid_o(dvalid_o), .wait_o(wait_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    vectors = 0;
   int    miscompares = 0;
   bit    chk_en = 1'b0;
   string cur_req = "R1";

   // reference model state (reset config per R1)
   bit m_sync = 1'b0;
   int m_lat = 4;
   bit m_pol = 1'b1;
   int m_hold = 1;
   bit m_early = 1'b0;
   bit m_rise = 1'b1;
   bit m_wrap = 1'b1;
   int m_len = 0;
   int q[$];
   int cur = 0;   // bit8 valid, bit7 wait flag, bits5:0 address

   function automatic int word_of(int a);
      return ((a * 40503) ^ 'h5A5A) & 'hFFFF;   // R13
   endfunction

   function automatic bit is_active();
      return m_rise ? (clk == 1'b1) : (clk == 1'b0);
   endfunction

   task automatic build(int a);
      int n;
      int ad;
      q.delete();
      for (int k = 0; k < m_lat; k++) begin
         bit w;
         w = m_early ? (k < m_lat - 1) : 1'b1;
         q.push_back(w ? (1 << 7) : 0);
      end
      n = (m_len != 0) ? m_len : 48;
      for (int i = 0; i < n; i++) begin
         if (m_len != 0 && m_wrap) ad = (a & ~(m_len - 1)) | ((a + i) & (m_len - 1));
         else ad = (a + i) % 64;
         for (int h = 0; h < m_hold; h++) q.push_back((1 << 8) | ad);
      end
   endtask

   always @(posedge clk or negedge clk) begin
      if (!rst_n) begin
         q.delete();
         cur = 0;
      end else if (is_active()) begin
         if (q.size() > 0) cur = q.pop_front();
         else cur = 0;
         if (!m_sync || ce_n) begin
            q.delete();
            cur = 0;
         end else if (!avd_n) begin
            build(int'(start_addr));
            cur = q.pop_front();
         end
      end
   end

   task automatic compare();
      bit ev;
      bit ew;
      int ed;
      bit bad;
      ev = cur[8] && !oe_n;
      ed = ev ? word_of(cur & 'h3F) : 0;
      ew = m_pol ? cur[7] : !cur[7];
      bad = 1'b0;
      vectors++;
      if (dvalid_o !== ev) begin
         bad = 1'b1;
         $display("FAIL %s (R3/R4/R5/R12) dvalid_o actual %0b expected %0b at %0t",
                  cur_req, dvalid_o, ev, $time);
      end
      if (int'(dout_o) != ed) begin
         bad = 1'b1;
         $display("FAIL %s (R6/R13) dout_o actual %h expected %h at %0t",
                  cur_req, dout_o, ed[15:0], $time);
      end
      if (wait_o !== ew) begin
         bad = 1'b1;
         $display("FAIL %s (R7/R8) wait_o actual %0b expected %0b at %0t",
                  cur_req, wait_o, ew, $time);
      end
      if (bad) miscompares++;
   endtask

   always @(posedge clk or negedge clk) begin
      if (chk_en && rst_n && is_active()) begin
         #4;
         compare();
      end
   end

   task automatic act_edge();
      if (m_rise) @(posedge clk);
      else @(negedge clk);
      #7;
   endtask

   // model decode follows R10 independently
   task automatic cfg_write(logic [15:0] c);
      chk_en = 1'b0;
      @(posedge clk); #7;
      cfg_wdata = c;
      cfg_we = 1'b1;
      @(posedge clk); #7;
      cfg_we = 1'b0;
      m_sync  = !c[15];
      m_lat   = (c[13:11] >= 2 && c[13:11] <= 6) ? int'(c[13:11]) : 4;
      m_pol   = c[10];
      m_hold  = c[9] ? 2 : 1;
      m_early = c[8];
      m_rise  = c[6];
      m_wrap  = !c[3];
      case (c[2:0])
         3'd1: m_len = 4;
         3'd2: m_len = 8;
         3'd3: m_len = 16;
         default: m_len = 0;
      endcase
      repeat (2) @(posedge clk);
      #7;
      chk_en = 1'b1;
   endtask

   task automatic burst(logic [15:0] c, int a, int edges, int oe_at, int re_at, int re_addr);
      int ne;
      ce_n = 1'b1;
      cfg_write(c);
      ne = edges;
      if (ne < 0) ne = (m_len != 0) ? (m_lat + m_len * m_hold + 2) : (m_lat + 20 * m_hold);
      ce_n = 1'b0;
      oe_n = 1'b0;
      avd_n = 1'b0;
      start_addr = AW'(a);
      act_edge();
      for (int e = 0; e < ne; e++) begin
         if (e == oe_at) oe_n = 1'b1;
         if (e == oe_at + 3) oe_n = 1'b0;
         if (e == re_at) begin
            avd_n = 1'b0;
            start_addr = AW'(re_addr);
         end else begin
            avd_n = 1'b1;
         end
         act_edge();
      end
      avd_n = 1'b1;
      ce_n = 1'b1;
      repeat (3) act_edge();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      miscompares++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [15:0] c;
      // R1: outputs during reset
      repeat (3) @(posedge clk);
      #3;
      cur_req = "R1";
      compare();
      @(posedge clk); #7;
      rst_n = 1'b1;
      act_edge();
      compare();

      // R1 / R2: reset configuration keeps the engine idle
      chk_en = 1'b1;
      ce_n = 1'b0; oe_n = 1'b0; avd_n = 1'b0; start_addr = 6'd9;
      act_edge();
      avd_n = 1'b1;
      repeat (10) act_edge();
      ce_n = 1'b1;
      act_edge();

      // R2: explicit asynchronous selection with other fields set
      cur_req = "R2";
      burst(16'h8000 | (16'd3 << 11) | 16'h0080 | 16'h0040 | 16'd1, 12, 20, -1, -1, 0);

      // R3 R4 R5 R6 R7 R8 R9 R13: full sweep
      cur_req = "R3/R4/R5/R6/R7/R8/R9/R13";
      for (int lat = 2; lat <= 6; lat++) begin
         for (int li = 0; li < 4; li++) begin
            for (int wr = 0; wr < 2; wr++) begin
               for (int hd = 0; hd < 2; hd++) begin
                  int idx;
                  int lc;
                  idx = ((lat * 4 + li) * 2 + wr) * 2 + hd;
                  lc = (li == 3) ? 7 : li + 1;
                  c = 16'(lat << 11) | 16'h0080 | 16'(lc);
                  if (idx % 3 != 0) c = c | 16'h0400;
                  if (hd == 1)      c = c | 16'h0200;
                  if ((idx / 2) % 2 == 1) c = c | 16'h0100;
                  if (idx % 5 != 2) c = c | 16'h0040;
                  if (wr == 1)      c = c | 16'h0008;
                  burst(c, (idx * 11 + 5) % 64, -1, -1, -1, 0);
               end
            end
         end
      end

      // R9: falling edge with wrap and hold, explicit
      cur_req = "R9";
      burst(16'(3 << 11) | 16'h0400 | 16'h0200 | 16'h0080 | 16'd2, 61, -1, -1, -1, 0);

      // R10: illegal latency and length codes, B7 written 0
      cur_req = "R10";
      burst(16'h0400 | 16'h0040 | 16'd5, 58, -1, -1, -1, 0);
      burst(16'(7 << 11) | 16'h0040 | 16'h0008 | 16'd0, 30, -1, -1, -1, 0);

      // R11: abort by ce_n, then restart during a burst
      cur_req = "R11";
      burst(16'(3 << 11) | 16'h0400 | 16'h0200 | 16'h00C0 | 16'd3, 20, 8, -1, -1, 0);
      burst(16'(2 << 11) | 16'h0400 | 16'h00C0 | 16'd3, 5, 40, -1, 6, 44);

      // R12: output gating mid burst
      cur_req = "R12";
      burst(16'(4 << 11) | 16'h0400 | 16'h00C0 | 16'h0008 | 16'd2, 50, -1, 6, -1, 0);

      chk_en = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule